// File: doc/BRIEF.md
# Weighted Pseudo-Random Pattern Generator

This block feeds a circuit under self-test with pseudo-random stimulus in which each output bit is 1 with a chosen probability rather than always one half. A free-running Galois shift register supplies fair random bits. Each output bit ANDs one to four of them together, which pulls its 1-probability down to 1/2, 1/4, 1/8 or 1/16. An optional complement then maps the same level to 1/2, 3/4, 7/8 or 15/16.

Every output bit has its own 2-bit weight code and invert flag. These pairs sit in a small bank of weight sets, three by default, that are written through a configuration port. A run-time set index picks which set drives the shaper. A three-state controller sequences the block. IDLE keeps the register frozen and the output at zero. LOAD copies the selected set into the active weight register in a single cycle. RUN advances the register and emits one weighted vector per cycle.

The controller has four named transitions:
- *start*: IDLE to LOAD, taken when `en` is high.
- *commit*: LOAD to RUN, always taken after one cycle.
- *halt*: RUN to IDLE, taken when `en` is low.
- *reselect*: RUN to LOAD, taken when `set_sel` differs from the set index latched at the last LOAD.

Top module: `wpat_gen`

## Requirements
- R1: During and after reset, `pattern_valid` is 0 and `pattern` is all zeros. The internal shift register takes a non-zero seed at reset and never holds zero afterwards.
- R2: Weight code 0 gives output bit i a 1-probability of 1/2 (8/16), whether or not its invert flag is set. Output bit i draws only on register bits 4i to 4i+3.
- R3: Weight code 1 (binary 01) gives 1/4 (4/16) with invert 0 and 3/4 (12/16) with invert 1.
- R4: Weight code 2 (binary 10) gives 1/8 (2/16) with invert 0 and 7/8 (14/16) with invert 1.
- R5: Weight code 3 (binary 11) gives 1/16 with invert 0 and 15/16 with invert 1.
- R6: A write with `cfg_we`=1 stores {`cfg_inv`,`cfg_code`} for bit `cfg_bit` of set `cfg_set`. Writes to a set index at or above the number of sets (3 by default) are ignored. A `set_sel` at or above that number selects the last set. After reset every entry is code 0 with invert 0.
- R7: With `en` raised in IDLE, `pattern_valid` first reads 1 after the third rising edge. A change of `set_sel` while running drops `pattern_valid` for exactly one cycle, two edges later. After `en` falls, `pattern_valid` stays 1 for one more edge and then reads 0.
- R8: Whenever `pattern_valid` is 0, including IDLE and LOAD cycles, `pattern` is all zeros and the shift register holds its value.
- R9: Weights are copied from the bank only in LOAD. A bank write to the set in use has no effect on the output until the next LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request |
| set_sel | input | SEL_W (2) | Weight set to use |
| cfg_we | input | 1 | Bank write strobe |
| cfg_set | input | SEL_W (2) | Set index of the write |
| cfg_bit | input | BIT_W (3) | Output bit index of the write |
| cfg_code | input | 2 | Weight code written |
| cfg_inv | input | 1 | Invert flag written |
| pattern | output | OUT_W (8) | Weighted test vector |
| pattern_valid | output | 1 | High when `pattern` carries a generated vector |

## Verification
A controller stuck in the wrong state shows at `pattern_valid` within three cycles of the stimulus that should have moved it. A fault that reaches the shape of the vectors gives no single wrong cycle. This covers a wrong code or invert flag in the active register, a missed load, and a bad tap choice. Such a fault only shows up as a shifted 1-frequency on one output bit, so it is judged over windows of several thousand vectors. Adjacent probability levels differ by at least 1/16, and the tolerance is set well inside half of that gap, so each level is told apart from its neighbours.

// File: rtl/wpat_pkg.sv
package wpat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } wpat_state_e;

    typedef struct packed {
        logic       inv;
        logic [1:0] code;
    } wpat_weight_t;

    localparam int SRC_PER_BIT = 4;

endpackage

// File: rtl/wpat_lfsr.sv
module wpat_lfsr #(
    parameter int          WIDTH = 32,
    parameter logic [WIDTH-1:0] SEED = 32'hACE1_5EED,
    parameter logic [WIDTH-1:0] MASK = 32'h8020_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    always_comb begin
        state_d = {1'b0, state_q[WIDTH-1:1]} ^ (state_q[0] ? MASK : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= SEED;
        else if (adv) state_q <= state_d;
    end

    assign state = state_q;

    assert_state_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));

endmodule

// File: rtl/wpat_bank.sv
module wpat_bank
    import wpat_pkg::*;
#(
    parameter int OUT_W    = 8,
    parameter int NUM_SETS = 3,
    parameter int SEL_W    = 2,
    parameter int BIT_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_set,
    input  logic [BIT_W-1:0]              cfg_bit,
    input  wpat_weight_t                  cfg_wt,
    input  logic                          load,
    input  logic [SEL_W-1:0]              load_set,
    output wpat_weight_t [OUT_W-1:0]      active
);

    localparam logic [SEL_W-1:0] LAST_SET = SEL_W'(NUM_SETS - 1);

    wpat_weight_t             bank_q [NUM_SETS][OUT_W];
    wpat_weight_t [OUT_W-1:0] active_q;
    logic [SEL_W-1:0]         rd_idx;

    always_comb begin
        rd_idx = (int'(load_set) < NUM_SETS) ? load_set : LAST_SET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int b = 0; b < OUT_W; b++)
                    bank_q[s][b] <= '0;
        end else if (cfg_we) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int b = 0; b < OUT_W; b++)
                    if (cfg_set == SEL_W'(s) && cfg_bit == BIT_W'(b))
                        bank_q[s][b] <= cfg_wt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (load) begin
            for (int b = 0; b < OUT_W; b++)
                active_q[b] <= bank_q[rd_idx][b];
        end
    end

    assign active = active_q;

    assert_active_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active_q));

endmodule

// File: rtl/wpat_shaper.sv
module wpat_shaper
    import wpat_pkg::*;
#(
    parameter int OUT_W  = 8,
    parameter int SRC_W  = 32
) (
    input  logic [SRC_W-1:0]           src,
    input  wpat_weight_t [OUT_W-1:0]   wts,
    output logic [OUT_W-1:0]           y
);

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        localparam int BASE = i * SRC_PER_BIT;
        logic [SRC_PER_BIT-1:0] nib;
        logic                   anded;

        assign nib = src[BASE +: SRC_PER_BIT];

        always_comb begin
            unique case (wts[i].code)
                2'd0:    anded = nib[0];
                2'd1:    anded = &nib[1:0];
                2'd2:    anded = &nib[2:0];
                default: anded = &nib[3:0];
            endcase
            y[i] = anded ^ wts[i].inv;
        end
    end

endmodule

// File: rtl/wpat_ctrl.sv
module wpat_ctrl
    import wpat_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] set_sel,
    output logic             load,
    output logic             run,
    output logic [SEL_W-1:0] load_set
);

    wpat_state_e      state_q;
    wpat_state_e      state_d;
    logic [SEL_W-1:0] cur_set_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_set_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOAD) cur_set_q <= set_sel;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_RUN;
            ST_RUN: begin
                if (!en)                         state_d = ST_IDLE;
                else if (set_sel != cur_set_q)   state_d = ST_LOAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = (state_q == ST_LOAD);
        run      = (state_q == ST_RUN);
        load_set = set_sel;
    end

    assert_load_to_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_RUN));

    assert_halt_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !en) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/wpat_gen.sv
module wpat_gen
    import wpat_pkg::*;
#(
    parameter int OUT_W    = 8,
    parameter int NUM_SETS = 3,
    parameter int LFSR_W   = 32,
    parameter logic [LFSR_W-1:0] SEED = 32'hACE1_5EED,
    parameter logic [LFSR_W-1:0] MASK = 32'h8020_0003,
    localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int BIT_W = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] set_sel,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_set,
    input  logic [BIT_W-1:0] cfg_bit,
    input  logic [1:0]       cfg_code,
    input  logic             cfg_inv,
    output logic [OUT_W-1:0] pattern,
    output logic             pattern_valid
);

    logic                     load;
    logic                     run;
    logic [SEL_W-1:0]         load_set;
    logic [LFSR_W-1:0]        rnd;
    wpat_weight_t             cfg_wt;
    wpat_weight_t [OUT_W-1:0] active;
    logic [OUT_W-1:0]         shaped;

    assign cfg_wt = '{inv: cfg_inv, code: cfg_code};

    wpat_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .set_sel  (set_sel),
        .load     (load),
        .run      (run),
        .load_set (load_set)
    );

    wpat_bank #(
        .OUT_W    (OUT_W),
        .NUM_SETS (NUM_SETS),
        .SEL_W    (SEL_W),
        .BIT_W    (BIT_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_set  (cfg_set),
        .cfg_bit  (cfg_bit),
        .cfg_wt   (cfg_wt),
        .load     (load),
        .load_set (load_set),
        .active   (active)
    );

    wpat_lfsr #(
        .WIDTH (LFSR_W),
        .SEED  (SEED),
        .MASK  (MASK)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .state (rnd)
    );

    wpat_shaper #(
        .OUT_W (OUT_W),
        .SRC_W (LFSR_W)
    ) u_shaper (
        .src (rnd),
        .wts (active),
        .y   (shaped)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern       <= '0;
            pattern_valid <= 1'b0;
        end else if (run) begin
            pattern       <= shaped;
            pattern_valid <= 1'b1;
        end else begin
            pattern       <= '0;
            pattern_valid <= 1'b0;
        end
    end

    assert_valid_follows_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> pattern_valid);

endmodule

// File: tb/wpat_gen_bench.sv
module wpat_gen_bench;

    localparam int OUT_W = 8;
    localparam int NSETS = 3;
    localparam int WIN   = 8192;
    localparam int TOL   = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [1:0]       set_sel = '0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_set = '0;
    logic [2:0]       cfg_bit = '0;
    logic [1:0]       cfg_code = '0;
    logic             cfg_inv = 1'b0;
    logic [OUT_W-1:0] pattern;
    logic             pattern_valid;

    int total = 0;
    int bad   = 0;

    int mdl [NSETS][OUT_W];
    int act [OUT_W];

    string            tag_q [$];
    logic [4*OUT_W-1:0] exp_q [$];

    always #5 clk = ~clk;

    wpat_gen u_wpat_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .set_sel       (set_sel),
        .cfg_we        (cfg_we),
        .cfg_set       (cfg_set),
        .cfg_bit       (cfg_bit),
        .cfg_code      (cfg_code),
        .cfg_inv       (cfg_inv),
        .pattern       (pattern),
        .pattern_valid (pattern_valid)
    );

    function automatic int exp16(input int code, input bit inv);
        int base;
        base = 16 >> (code + 1);
        return inv ? 16 - base : base;
    endfunction

    task automatic check(input string req, input int actual, input int expect_v);
        total++;
        if (actual != expect_v) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expect_v);
        end
    endtask

    task automatic cfg_write(input int s, input int b, input int code, input bit inv);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_set  = 2'(s);
        cfg_bit  = 3'(b);
        cfg_code = 2'(code);
        cfg_inv  = inv;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s < NSETS) mdl[s][b] = exp16(code, inv);
    endtask

    task automatic activate(input int s);
        int k;
        k = (s < NSETS) ? s : NSETS - 1;
        for (int b = 0; b < OUT_W; b++) act[b] = mdl[k][b];
    endtask

    // driver side of the scoreboard: queue expectation, wait for the monitor
    task automatic measure(input string req);
        logic [4*OUT_W-1:0] e;
        for (int b = 0; b < OUT_W; b++) e[4*b +: 4] = 4'(act[b]);
        tag_q.push_back(req);
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    // monitor: count ones per bit over a window of valid vectors
    initial begin
        forever begin
            int cnt [OUT_W];
            int n;
            logic [4*OUT_W-1:0] e;
            string req;
            wait (exp_q.size() > 0);
            for (int b = 0; b < OUT_W; b++) cnt[b] = 0;
            n = 0;
            while (n < WIN) begin
                @(negedge clk);
                if (pattern_valid) begin
                    n++;
                    for (int b = 0; b < OUT_W; b++) cnt[b] += int'(pattern[b]);
                end
            end
            req = tag_q.pop_front();
            e   = exp_q[0];
            for (int b = 0; b < OUT_W; b++) begin
                int want;
                want = int'(e[4*b +: 4]) * (WIN / 16);
                total++;
                if (cnt[b] > want + TOL || cnt[b] < want - TOL) begin
                    bad++;
                    $display("FAIL %s bit %0d: actual=%0d expected=%0d (+/-%0d)",
                             req, b, cnt[b], want, TOL);
                end
            end
            void'(exp_q.pop_front());
        end
    end

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int b = 0; b < OUT_W; b++) mdl[s][b] = 8;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(pattern_valid), 0);
        check("R1 pattern in reset", int'(pattern), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(pattern_valid), 0);
        check("R1 pattern after reset", int'(pattern), 0);

        // set 0: code = b/2, inv = b%2 ; set 1: reversed codes, flipped inv
        for (int b = 0; b < OUT_W; b++) cfg_write(0, b, b / 2, bit'(b % 2));
        for (int b = 0; b < OUT_W; b++) cfg_write(1, b, 3 - b / 2, bit'((b % 2) ^ 1));
        check("R8 idle pattern during writes", int'(pattern), 0);

        // R7: start timing
        set_sel = 2'd0;
        en = 1'b1;
        activate(0);
        @(negedge clk); check("R7 start edge1", int'(pattern_valid), 0);
        @(negedge clk); check("R7 start edge2", int'(pattern_valid), 0);
        check("R8 pattern in load", int'(pattern), 0);
        @(negedge clk); check("R7 start edge3", int'(pattern_valid), 1);

        // R2 R3 R4 R5: all levels, set 0
        measure("R2/R3/R4/R5 set0");

        // R7: reselect drops valid for one cycle
        set_sel = 2'd1;
        activate(1);
        @(negedge clk); check("R7 reselect edge1", int'(pattern_valid), 1);
        @(negedge clk); check("R7 reselect edge2", int'(pattern_valid), 0);
        check("R8 pattern in reselect load", int'(pattern), 0);
        @(negedge clk); check("R7 reselect edge3", int'(pattern_valid), 1);
        measure("R2/R3/R4/R5 set1");

        // R9: write to set in use is not seen until next load
        cfg_write(1, 0, 0, 1'b0);
        measure("R9 before reload");
        set_sel = 2'd0;
        repeat (4) @(negedge clk);
        set_sel = 2'd1;
        activate(1);
        repeat (4) @(negedge clk);
        measure("R9 after reload");

        // R6: writes to out-of-range set ignored; out-of-range select uses last set
        for (int b = 0; b < OUT_W; b++) cfg_write(3, b, 3, 1'b0);
        set_sel = 2'd3;
        activate(3);
        repeat (4) @(negedge clk);
        measure("R6 clamp to last set");

        // R7/R8: halt
        en = 1'b0;
        @(negedge clk); check("R7 halt edge1", int'(pattern_valid), 1);
        @(negedge clk); check("R7 halt edge2", int'(pattern_valid), 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R8 idle pattern zero", int'(pattern), 0);
        end

        finish_run();
    end

endmodule